// File: doc/BRIEF.md
# Thermal Alarm and Shutdown Monitor

The monitor watches several temperature channels. Each channel delivers a 12-bit code with a one-cycle valid strobe, and a smaller code means a hotter die. For every channel the block holds three programmable codes: a hot trip point, a release (hysteresis) point and a shutdown trip point. It turns crossings of these points into sticky status bits, raises one interrupt line through a per-bit enable mask, and holds a shutdown request high for as long as any shutdown status bit remains set.

Software uses a simple register port with a single-cycle write and a combinational read. It programs the thresholds and the enables, reads the status, and writes the value it read back to that register to clear exactly the events it has handled. The latest code of each channel can also be read back. Conversion to degrees and sensor calibration are outside this block.

Top module: `thermal_mon`

## Requirements
- R1: Channel k has an alarm register at byte offset 0x50+4k. Bits 27:16 hold the hot code and bits 11:0 hold the release code. All other bits are not stored and read back as zero.
- R2: Channel k has a shutdown register at byte offset 0x60+4k. Bits 27:16 hold the shutdown code, and all other bits read as zero.
- R3: A strobed sample whose code is strictly below the channel's hot code, arriving while that channel's alarm is inactive, makes the alarm active. It also sets status bit k, which is visible in the status register at offset 0x48 after the next rising clock edge. A code equal to or above the hot code sets nothing.
- R4: Once active, an alarm stays active until a strobed sample is strictly above the release code. While the alarm is active, further hot samples set no status bit, and a sample equal to the release code does not end the alarm.
- R5: Every strobed sample strictly below the channel's shutdown code sets status bit 4+k. A sample equal to the shutdown code does not.
- R6: Writing the status register clears each status bit written with 1 and leaves each bit written with 0 unchanged. A status bit never clears in any other way.
- R7: If a clear write and a new event for the same bit arrive in the same cycle, the bit stays set.
- R8: The enable register at offset 0x44 uses the status bit positions: bits 0..2 for alarms and bits 4..6 for shutdowns. Other bits read as zero. The interrupt output is high exactly when some status bit and its enable are both 1.
- R9: The shutdown request output is high whenever any shutdown status bit is set, whatever the enables are, and it stays high until those bits are cleared.
- R10: After reset, all thresholds, enables, status bits, alarm states and stored codes are zero, and both outputs are low.
- R11: Offset 0x80+4k returns channel k's code from its most recent strobe in bits 11:0. A code presented without the strobe changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 36 | Channel codes, channel k in bits 12k+11:12k |
| code_vld_i | input | 3 | Per-channel sample strobe |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| irq_o | output | 1 | Enabled-status interrupt |
| shutdown_req_o | output | 1 | Level shutdown request |

## Verification
The hardest case to reach is a clear write and a fresh alarm event for the same bit landing in the same cycle. An alarm only fires on an inactive-to-active transition, so the channel first has to be released with a sample above its release code. Only then can the bench present a hot sample in the very cycle of the clear. The bench runs that sequence directly. It also steps samples exactly onto the hot, release and shutdown codes to pin down the strict comparisons. It then runs a seeded random mix of near-threshold samples and partial clear masks, checked against a bench model of the alarm state.

// File: rtl/thermal_mon_pkg.sv
package thermal_mon_pkg;

    localparam int NUM_CH     = 3;
    localparam int CODE_W     = 12;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int SHUT_LSB   = 4;
    localparam int STAT_W     = SHUT_LSB + NUM_CH;
    localparam int HI_LSB     = 16;

    localparam logic [ADDR_W-1:0] OFS_IRQ_EN = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_ALARM  = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_SHUT   = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_CODE   = 8'h80;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [STAT_W-1:0] stat_t;

    typedef struct packed {
        code_t hot;
        code_t hyst;
        code_t shut;
    } thr_t;

    typedef struct packed {
        logic alarm_set;
        logic shut_set;
    } chan_evt_t;

    function automatic logic [ADDR_W-1:0] bank_addr(input logic [ADDR_W-1:0] base, input int idx);
        return base + ADDR_W'(4 * idx);
    endfunction

    function automatic stat_t stat_mask();
        stat_t m = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            m[k]            = 1'b1;
            m[SHUT_LSB + k] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] put_hi(input code_t c);
        logic [DATA_W-1:0] w = '0;
        w[HI_LSB +: CODE_W] = c;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] put_lo(input code_t c);
        logic [DATA_W-1:0] w = '0;
        w[CODE_W-1:0] = c;
        return w;
    endfunction

endpackage

// File: rtl/thermal_regs.sv
module thermal_regs
    import thermal_mon_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output thr_t  [NUM_CH-1:0]        thr_o,
    output stat_t                     en_o
);

    thr_t [NUM_CH-1:0] thr_q;
    stat_t             en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
            en_q  <= '0;
        end else if (wr_en) begin
            if (addr == OFS_IRQ_EN)
                en_q <= wdata[STAT_W-1:0] & stat_mask();
            for (int k = 0; k < NUM_CH; k++) begin
                if (addr == bank_addr(OFS_ALARM, k)) begin
                    thr_q[k].hot  <= wdata[HI_LSB +: CODE_W];
                    thr_q[k].hyst <= wdata[CODE_W-1:0];
                end
                if (addr == bank_addr(OFS_SHUT, k))
                    thr_q[k].shut <= wdata[HI_LSB +: CODE_W];
            end
        end
    end

    assign thr_o = thr_q;
    assign en_o  = en_q;

endmodule

// File: rtl/thermal_chan.sv
module thermal_chan
    import thermal_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      vld,
    input  code_t     code,
    input  thr_t      thr,
    output chan_evt_t evt_o,
    output code_t     last_o
);

    logic  active_q;
    code_t last_q;
    logic  is_hot;
    logic  is_cool;

    // smaller code = hotter
    assign is_hot  = code < thr.hot;
    assign is_cool = code > thr.hyst;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            last_q   <= '0;
        end else if (vld) begin
            last_q <= code;
            if (!active_q && is_hot)
                active_q <= 1'b1;
            else if (active_q && is_cool)
                active_q <= 1'b0;
        end
    end

    assign evt_o.alarm_set = vld && !active_q && is_hot;
    assign evt_o.shut_set  = vld && (code < thr.shut);
    assign last_o          = last_q;

endmodule

// File: rtl/thermal_status.sv
module thermal_status
    import thermal_mon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t set_i,
    input  stat_t clr_i,
    input  stat_t en_i,
    output stat_t stat_o,
    output logic  irq_o,
    output logic  shut_req_o
);

    stat_t stat_q;

    // set wins over clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_i) | set_i;
    end

    assign stat_o     = stat_q;
    assign irq_o      = |(stat_q & en_i);
    assign shut_req_o = |stat_q[SHUT_LSB +: NUM_CH];

endmodule

// File: rtl/thermal_mon.sv
module thermal_mon
    import thermal_mon_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_CH*CODE_W-1:0]   code_i,
    input  logic [NUM_CH-1:0]          code_vld_i,
    input  logic                       reg_wr_i,
    input  logic [ADDR_W-1:0]          reg_addr_i,
    input  logic [DATA_W-1:0]          reg_wdata_i,
    output logic [DATA_W-1:0]          reg_rdata_o,
    output logic                       irq_o,
    output logic                       shutdown_req_o
);

    thr_t      [NUM_CH-1:0] thr_vec;
    stat_t                  en_vec;
    stat_t                  status_vec;
    stat_t                  set_vec;
    stat_t                  clr_vec;
    chan_evt_t [NUM_CH-1:0] evt_vec;
    code_t     [NUM_CH-1:0] last_vec;

    thermal_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_i),
        .addr  (reg_addr_i),
        .wdata (reg_wdata_i),
        .thr_o (thr_vec),
        .en_o  (en_vec)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        thermal_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .vld    (code_vld_i[k]),
            .code   (code_i[k*CODE_W +: CODE_W]),
            .thr    (thr_vec[k]),
            .evt_o  (evt_vec[k]),
            .last_o (last_vec[k])
        );
    end

    always_comb begin
        set_vec = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            set_vec[k]            = evt_vec[k].alarm_set;
            set_vec[SHUT_LSB + k] = evt_vec[k].shut_set;
        end
    end

    assign clr_vec = (reg_wr_i && reg_addr_i == OFS_STATUS)
                   ? (reg_wdata_i[STAT_W-1:0] & stat_mask()) : '0;

    thermal_status u_status (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_vec),
        .clr_i      (clr_vec),
        .en_i       (en_vec),
        .stat_o     (status_vec),
        .irq_o      (irq_o),
        .shut_req_o (shutdown_req_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == OFS_IRQ_EN) reg_rdata_o[STAT_W-1:0] = en_vec;
        if (reg_addr_i == OFS_STATUS) reg_rdata_o[STAT_W-1:0] = status_vec;
        for (int k = 0; k < NUM_CH; k++) begin
            if (reg_addr_i == bank_addr(OFS_ALARM, k))
                reg_rdata_o = put_hi(thr_vec[k].hot) | put_lo(thr_vec[k].hyst);
            if (reg_addr_i == bank_addr(OFS_SHUT, k))
                reg_rdata_o = put_hi(thr_vec[k].shut);
            if (reg_addr_i == bank_addr(OFS_CODE, k))
                reg_rdata_o = put_lo(last_vec[k]);
        end
    end

endmodule

// File: rtl/thermal_mon_checker.sv
module thermal_mon_checker
    import thermal_mon_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CH*CODE_W-1:0] code_i,
    input logic [NUM_CH-1:0]        code_vld_i,
    input logic                     reg_wr_i,
    input logic [ADDR_W-1:0]        reg_addr_i,
    input logic                     irq_o,
    input logic                     shutdown_req_o,
    input thr_t [NUM_CH-1:0]        thr_vec,
    input stat_t                    en_vec,
    input stat_t                    status_vec
);

    logic stat_wr;
    assign stat_wr = reg_wr_i && (reg_addr_i == OFS_STATUS);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        p_alarm_cause_r3: assert property (@(posedge clk) disable iff (rst)
            $rose(status_vec[k]) |->
                ($past(code_vld_i[k]) && ($past(code_i[k*CODE_W +: CODE_W]) < $past(thr_vec[k].hot))));

        p_shut_cause_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(status_vec[SHUT_LSB + k]) |->
                ($past(code_vld_i[k]) && ($past(code_i[k*CODE_W +: CODE_W]) < $past(thr_vec[k].shut))));
    end

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((status_vec & $past(status_vec)) == $past(status_vec)));

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (en_vec == '0) |-> !irq_o);

    p_shut_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (shutdown_req_o && !stat_wr) |=> shutdown_req_o);

endmodule

bind thermal_mon thermal_mon_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .code_i         (code_i),
    .code_vld_i     (code_vld_i),
    .reg_wr_i       (reg_wr_i),
    .reg_addr_i     (reg_addr_i),
    .irq_o          (irq_o),
    .shutdown_req_o (shutdown_req_o),
    .thr_vec        (thr_vec),
    .en_vec         (en_vec),
    .status_vec     (status_vec)
);

// File: tb/thermal_mon_test.sv
`timescale 1ns/1ps
module thermal_mon_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [35:0] code_i;
    logic [2:0]  code_vld_i;
    logic        reg_wr_i;
    logic [7:0]  reg_addr_i;
    logic [31:0] reg_wdata_i;
    logic [31:0] reg_rdata_o;
    logic        irq_o;
    logic        shutdown_req_o;

    always #2.5 clk = ~clk;

    thermal_mon uut (
        .clk            (clk),
        .rst            (rst),
        .code_i         (code_i),
        .code_vld_i     (code_vld_i),
        .reg_wr_i       (reg_wr_i),
        .reg_addr_i     (reg_addr_i),
        .reg_wdata_i    (reg_wdata_i),
        .reg_rdata_o    (reg_rdata_o),
        .irq_o          (irq_o),
        .shutdown_req_o (shutdown_req_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [11:0] m_hot [3];
    logic [11:0] m_hyst[3];
    logic [11:0] m_shut[3];
    logic [11:0] m_last[3];
    logic        m_act [3];
    logic [6:0]  m_stat;
    logic [6:0]  m_en;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    // one clock cycle of stimulus; model advances with the DUT
    task automatic cyc(input logic [2:0] vld, input logic [35:0] codes,
                       input logic wr, input logic [7:0] a, input logic [31:0] d);
        logic [6:0] set_v;
        logic [6:0] clr_v;
        set_v = '0;
        clr_v = '0;
        code_vld_i  = vld;
        code_i      = codes;
        reg_wr_i    = wr;
        reg_addr_i  = a;
        reg_wdata_i = d;
        for (int k = 0; k < 3; k++) begin
            if (vld[k]) begin
                logic [11:0] c;
                c = codes[k*12 +: 12];
                m_last[k] = c;
                if (c < m_shut[k]) set_v[4+k] = 1'b1;
                if (!m_act[k] && c < m_hot[k]) begin
                    set_v[k] = 1'b1;
                    m_act[k] = 1'b1;
                end else if (m_act[k] && c > m_hyst[k]) begin
                    m_act[k] = 1'b0;
                end
            end
        end
        if (wr) begin
            if (a == 8'h44) m_en = d[6:0] & 7'h77;
            if (a == 8'h48) clr_v = d[6:0] & 7'h77;
            for (int k = 0; k < 3; k++) begin
                if (a == 8'h50 + 8'(4*k)) begin
                    m_hot[k]  = d[27:16];
                    m_hyst[k] = d[11:0];
                end
                if (a == 8'h60 + 8'(4*k)) m_shut[k] = d[27:16];
            end
        end
        m_stat = (m_stat & ~clr_v) | set_v;
        @(posedge clk);
        @(negedge clk);
        code_vld_i = '0;
        reg_wr_i   = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(3'b000, code_i, 1'b1, a, d);
    endtask

    task automatic smp(input int ch, input logic [11:0] c);
        logic [35:0] v;
        v = code_i;
        v[ch*12 +: 12] = c;
        cyc(3'(1 << ch), v, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        rd(8'h48, d);
        chk(req, d, {25'b0, m_stat});
        chk(req, {31'b0, irq_o}, {31'b0, |(m_stat & m_en)});
        chk(req, {31'b0, shutdown_req_o}, {31'b0, |m_stat[6:4]});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        for (int k = 0; k < 3; k++) begin
            m_hot[k] = '0; m_hyst[k] = '0; m_shut[k] = '0; m_last[k] = '0; m_act[k] = 1'b0;
        end
        m_stat = '0; m_en = '0;
        rst = 1'b1; code_i = '0; code_vld_i = '0; reg_wr_i = 1'b0;
        reg_addr_i = '0; reg_wdata_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        rd(8'h50, d); chk("R10 alarm reg", d, 32'h0);
        rd(8'h64, d); chk("R10 shut reg", d, 32'h0);
        rd(8'h44, d); chk("R10 enable", d, 32'h0);
        rd(8'h88, d); chk("R10 code", d, 32'h0);
        check_all("R10 outputs");

        // R1 / R2 / R8 register fields
        wr(8'h50, 32'h0600_0700);
        rd(8'h50, d); chk("R1 alarm fields", d, 32'h0600_0700);
        wr(8'h54, 32'hF123_4567);
        rd(8'h54, d); chk("R1 masked bits", d, 32'h0123_0567);
        wr(8'h54, 32'h0600_0700);
        wr(8'h58, 32'h0800_0900);
        wr(8'h64, 32'hF400_FFFF);
        rd(8'h64, d); chk("R2 shut field", d, 32'h0400_0000);
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h44, d); chk("R8 enable positions", d, 32'h0000_0077);

        // R3 alarm trip, strict compare
        smp(0, 12'h600); check_all("R3 equal to hot");
        smp(0, 12'h5FF); check_all("R3 below hot");
        chk("R3 irq", {31'b0, irq_o}, 32'h1);

        // R6 clear, R4 hysteresis
        wr(8'h48, 32'h1); check_all("R6 clear alarm");
        smp(0, 12'h500); check_all("R4 still active");
        smp(0, 12'h700); check_all("R4 equal to release");
        smp(0, 12'h500); check_all("R4 no retrigger");
        smp(0, 12'h701); check_all("R4 release");
        smp(0, 12'h5FF); check_all("R4 retrigger after release");
        wr(8'h48, 32'h1);

        // R5 / R9 shutdown
        smp(1, 12'h400); check_all("R5 equal to shut");
        smp(1, 12'h3FF); check_all("R5 below shut");
        chk("R9 shut req", {31'b0, shutdown_req_o}, 32'h1);
        wr(8'h44, 32'h0);
        chk("R9 shut ignores enables", {31'b0, shutdown_req_o}, 32'h1);
        chk("R8 irq masked", {31'b0, irq_o}, 32'h0);
        wr(8'h48, 32'h0000_0001);
        check_all("R6 zero bits keep shut status");
        wr(8'h48, 32'h0000_0022);
        check_all("R9 shut cleared");
        wr(8'h44, 32'h77);

        // R7 set and clear in the same cycle
        smp(2, 12'h100); check_all("R7 prepare");
        smp(2, 12'hFFF);
        cyc(3'b100, {12'h100, code_i[23:0]}, 1'b1, 8'h48, 32'h4);
        check_all("R7 set beats clear");
        rd(8'h48, d); chk("R7 bit2 set", {31'b0, d[2]}, 32'h1);
        wr(8'h48, 32'h77);

        // R11 code readback and strobe gating
        smp(1, 12'h456);
        rd(8'h84, d); chk("R11 code", d, 32'h456);
        cyc(3'b000, {12'h0, 12'h123, 12'h0}, 1'b0, 8'h00, 32'h0);
        rd(8'h84, d); chk("R11 no strobe ignored", d, 32'h456);
        check_all("R11 no strobe no event");

        // random mix: R3 R4 R5 R6 R7 R8
        wr(8'h64, 32'h0450_0000);
        wr(8'h68, 32'h0300_0000);
        for (int i = 0; i < 600; i++) begin
            int unsigned op;
            logic [35:0] cv;
            logic [2:0]  vv;
            op = $urandom_range(0, 9);
            for (int k = 0; k < 3; k++) cv[k*12 +: 12] = 12'(12'h2F0 + $urandom_range(0, 12'h6A0));
            vv = 3'($urandom_range(0, 7));
            if (op < 6)       cyc(vv, cv, 1'b0, 8'h00, 32'h0);
            else if (op < 9)  cyc(vv, cv, 1'b1, 8'h48, $urandom);
            else              cyc(3'b000, cv, 1'b1, 8'h44, $urandom);
            check_all("R6 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule